// File: doc/BRIEF.md
# Address-Latched Multicart Program Bank Controller

This block selects which part of a large program ROM the CPU sees in its upper 32 KiB window ($8000–$FFFF) on a multi-game cartridge. Any CPU write into that window reconfigures the controller. The whole configuration comes from the write address; no data bus is used.

Address bits 9:8 act as a chip-select field. How that field is decoded depends on the ROM size fixed by the `PRG_MIB` parameter (1, 2, 3 or 4 MiB). A chip that is not populated makes the window read as open bus. The same write also picks a 32 KiB or a 16 KiB mapping and one of three nametable mirroring modes.

For every CPU read address, the controller returns a registered ROM byte address and an open-bus flag one clock later. The mirroring code it outputs is the latched state.

Top module: `amb_prg_mapper`

## Requirements
- R1: Configuration changes only on a clock edge where `cpu_wr_en` is 1 and `cpu_wr_addr[15]` is 1. A strobed write below $8000, or an address without the strobe, leaves all outputs as they were.
- R2: The 7-bit bank number is `{cpu_wr_addr[9:8], cpu_wr_addr[4:0]}`. When the latching write had bit 11 = 0, a window read at `rd_addr` maps to `bank*32768 + rd_addr[14:0]`.
- R3: When the latching write had bit 11 = 1, a window read maps to `bank*32768 + cpu_wr_addr[12]*16384 + rd_addr[13:0]`, so one 16 KiB half appears in both halves of the window.
- R4: With `PRG_MIB`=1, any nonzero value of bits 9:8 makes the window open bus.
- R5: With `PRG_MIB`=2, bits 9:8 = 01 or 11 give open bus, and 10 gives bank `0x20 | bits[4:0]`.
- R6: With `PRG_MIB`=3, bits 9:8 = 01 give open bus, 10 gives bank `0x20 | bits[4:0]`, and 11 gives bank `0x40 | bits[4:0]`.
- R7: With `PRG_MIB`=4, bits 9:8 are used unchanged and `open_bus` is never 1.
- R8: `mirror_mode` is 2'b10 (single-screen lower) if write bit 10 is set. Otherwise it is 2'b01 (horizontal) if bit 13 is set. Otherwise it is 2'b00 (vertical). The value 2'b11 never occurs.
- R9: Synchronous active-high reset gives 32 KiB mode, bank 0, vertical mirroring, `prg_addr` 0 and `open_bus` 0.
- R10: `prg_addr` and `open_bus` are registered: after edge k they reflect `rd_addr` and the configuration held before edge k. `open_bus` is 1 only for reads with `rd_addr[15]`=1 under an open-bus configuration, and a later latching write without that condition clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | CPU write strobe |
| cpu_wr_addr | input | 16 | CPU write address; holds the whole configuration |
| rd_addr | input | 16 | CPU read address to translate |
| prg_addr | output | 22 | Registered ROM byte address |
| open_bus | output | 1 | Registered flag: the read returns undriven data |
| mirror_mode | output | 2 | Nametable mirroring code |

## Verification
A wrong bank or mode register shows up at `prg_addr` on the very next read, as a wrong high bit field or as a 16 KiB half that differs between $8000 and $C000. A wrong chip-select decode shows as `open_bus` being raised or missing one cycle after a window read. A wrong mirroring register appears on `mirror_mode` in the cycle right after the write. The bench sweeps the chip-select field, the low bank bits, both mode bits and every mirroring combination on all four size variants in parallel, so each wrong state is exposed within one read.

// File: rtl/amb_pkg.sv
package amb_pkg;
  localparam int BANK_W = 7;
  localparam int WIN_W  = 15;
  localparam int ROM_AW = BANK_W + WIN_W;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'b00,
    MIR_HORZ   = 2'b01,
    MIR_SINGLE = 2'b10
  } mirror_e;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic              mode16;
    logic              half_hi;
    logic              nobus;
    mirror_e           mirror;
  } cfg_t;
endpackage

// File: rtl/amb_cfg_decode.sv
module amb_cfg_decode
  import amb_pkg::*;
#(
  parameter int PRG_MIB = 4
) (
  input  logic [15:8] wa_hi,
  input  logic [4:0]  wa_lo,
  output cfg_t        cfg
);
  logic [1:0] sel;
  logic [4:0] low;
  logic [1:0] bank_hi;
  logic       nobus;

  assign sel = wa_hi[9:8];
  assign low = wa_lo;

  generate
    if (PRG_MIB == 1) begin : g_1m
      always_comb begin
        bank_hi = sel;
        nobus   = (sel != 2'b00);
      end
    end else if (PRG_MIB == 2) begin : g_2m
      always_comb begin
        bank_hi = sel;
        nobus   = 1'b0;
        case (sel)
          2'b01, 2'b11: nobus   = 1'b1;
          2'b10:        bank_hi = 2'b01;
          default:      ;
        endcase
      end
    end else if (PRG_MIB == 3) begin : g_3m
      always_comb begin
        bank_hi = sel;
        nobus   = 1'b0;
        case (sel)
          2'b01:   nobus   = 1'b1;
          2'b10:   bank_hi = 2'b01;
          2'b11:   bank_hi = 2'b10;
          default: ;
        endcase
      end
    end else begin : g_4m
      always_comb begin
        bank_hi = sel;
        nobus   = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    cfg.bank    = {bank_hi, low};
    cfg.mode16  = wa_hi[11];
    cfg.half_hi = wa_hi[12];
    cfg.nobus   = nobus;
    if (wa_hi[10])      cfg.mirror = MIR_SINGLE;
    else if (wa_hi[13]) cfg.mirror = MIR_HORZ;
    else                cfg.mirror = MIR_VERT;
  end

  logic unused_bits;
  assign unused_bits = ^{wa_hi[15:14]};
endmodule

// File: rtl/amb_cfg_reg.sv
module amb_cfg_reg
  import amb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  cfg_t cfg_d,
  output cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.bank    <= '0;
      cfg_q.mode16  <= 1'b0;
      cfg_q.half_hi <= 1'b0;
      cfg_q.nobus   <= 1'b0;
      cfg_q.mirror  <= MIR_VERT;
    end else if (load) begin
      cfg_q <= cfg_d;
    end
  end
endmodule

// File: rtl/amb_prg_xlate.sv
module amb_prg_xlate
  import amb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  cfg_t              cfg,
  input  logic [15:0]       rd_addr,
  output logic [ROM_AW-1:0] prg_addr,
  output logic              open_bus
);
  logic [WIN_W-1:0]  offset;
  logic [ROM_AW-1:0] addr_d;

  always_comb begin
    if (cfg.mode16) offset = {cfg.half_hi, rd_addr[WIN_W-2:0]};
    else            offset = rd_addr[WIN_W-1:0];
    addr_d = {cfg.bank, offset};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_addr <= '0;
      open_bus <= 1'b0;
    end else begin
      prg_addr <= addr_d;
      open_bus <= cfg.nobus & rd_addr[15];
    end
  end
endmodule

// File: rtl/amb_prg_mapper.sv
module amb_prg_mapper
  import amb_pkg::*;
#(
  parameter int PRG_MIB = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr_en,
  input  logic [15:0]       cpu_wr_addr,
  input  logic [15:0]       rd_addr,
  output logic [ROM_AW-1:0] prg_addr,
  output logic              open_bus,
  output logic [1:0]        mirror_mode
);
  cfg_t cfg_next;
  cfg_t cfg_cur;
  logic latch;

  assign latch = cpu_wr_en & cpu_wr_addr[15];

  amb_cfg_decode #(.PRG_MIB(PRG_MIB)) u_dec (
    .wa_hi (cpu_wr_addr[15:8]),
    .wa_lo (cpu_wr_addr[4:0]),
    .cfg   (cfg_next)
  );

  amb_cfg_reg u_reg (
    .clk   (clk),
    .rst   (rst),
    .load  (latch),
    .cfg_d (cfg_next),
    .cfg_q (cfg_cur)
  );

  amb_prg_xlate u_xl (
    .clk      (clk),
    .rst      (rst),
    .cfg      (cfg_cur),
    .rd_addr  (rd_addr),
    .prg_addr (prg_addr),
    .open_bus (open_bus)
  );

  assign mirror_mode = cfg_cur.mirror;
endmodule

// File: rtl/amb_prg_mapper_chk.sv
module amb_prg_mapper_chk #(
  parameter int PRG_MIB = 4,
  parameter int AW      = 22
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_wr_en,
  input logic [15:0]   cpu_wr_addr,
  input logic [15:0]   rd_addr,
  input logic [AW-1:0] prg_addr,
  input logic          open_bus,
  input logic [1:0]    mirror_mode
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R1
  low_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !(cpu_wr_en && cpu_wr_addr[15])) |=> $stable(mirror_mode));

  // R8
  single_screen_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr_en && cpu_wr_addr[15] && cpu_wr_addr[10]) |=> (mirror_mode == 2'b10));

  // R8
  mirror_code_chk: assert property (@(posedge clk) disable iff (rst)
    mirror_mode != 2'b11);

  // R10
  bus_only_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && open_bus) |-> $past(rd_addr[15]));

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !open_bus) |-> (prg_addr[13:0] == $past(rd_addr[13:0])));

  generate
    if (PRG_MIB == 4) begin : g_full
      // R7
      never_open_chk: assert property (@(posedge clk) disable iff (rst)
        !open_bus);
    end
  endgenerate
endmodule

bind amb_prg_mapper amb_prg_mapper_chk #(.PRG_MIB(PRG_MIB), .AW(amb_pkg::ROM_AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cpu_wr_en   (cpu_wr_en),
  .cpu_wr_addr (cpu_wr_addr),
  .rd_addr     (rd_addr),
  .prg_addr    (prg_addr),
  .open_bus    (open_bus),
  .mirror_mode (mirror_mode)
);

// File: tb/tb_amb_prg_mapper.sv
module tb_amb_prg_mapper;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 22;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_wr_en = 1'b0;
  logic [15:0] cpu_wr_addr = '0;
  logic [15:0] rd_addr = '0;

  logic [AW-1:0] pa [4];
  logic          ob [4];
  logic [1:0]    mm [4];

  int checks = 0;
  int errors = 0;
  logic [15:0] last_w [4];
  bit wd_fired = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  amb_prg_mapper #(.PRG_MIB(4)) dut (
    .clk(clk), .rst(rst), .cpu_wr_en(cpu_wr_en), .cpu_wr_addr(cpu_wr_addr),
    .rd_addr(rd_addr), .prg_addr(pa[3]), .open_bus(ob[3]), .mirror_mode(mm[3]));
  amb_prg_mapper #(.PRG_MIB(1)) dut_1m (
    .clk(clk), .rst(rst), .cpu_wr_en(cpu_wr_en), .cpu_wr_addr(cpu_wr_addr),
    .rd_addr(rd_addr), .prg_addr(pa[0]), .open_bus(ob[0]), .mirror_mode(mm[0]));
  amb_prg_mapper #(.PRG_MIB(2)) dut_2m (
    .clk(clk), .rst(rst), .cpu_wr_en(cpu_wr_en), .cpu_wr_addr(cpu_wr_addr),
    .rd_addr(rd_addr), .prg_addr(pa[1]), .open_bus(ob[1]), .mirror_mode(mm[1]));
  amb_prg_mapper #(.PRG_MIB(3)) dut_3m (
    .clk(clk), .rst(rst), .cpu_wr_en(cpu_wr_en), .cpu_wr_addr(cpu_wr_addr),
    .rd_addr(rd_addr), .prg_addr(pa[2]), .open_bus(ob[2]), .mirror_mode(mm[2]));

  function automatic logic exp_bus(int sz, logic [15:0] w, logic [15:0] r);
    logic [1:0] h = w[9:8];
    logic b;
    case (sz)
      1:       b = (h != 2'b00);
      2:       b = (h == 2'b01) || (h == 2'b11);
      3:       b = (h == 2'b01);
      default: b = 1'b0;
    endcase
    return b & r[15];
  endfunction

  function automatic logic [AW-1:0] exp_addr(int sz, logic [15:0] w, logic [15:0] r);
    int bank = (int'(w[9:8]) * 32) + int'(w[4:0]);
    int off;
    if (sz == 2 && w[9:8] == 2'b10) bank = 32 + int'(w[4:0]);
    if (sz == 3 && w[9:8] == 2'b10) bank = 32 + int'(w[4:0]);
    if (sz == 3 && w[9:8] == 2'b11) bank = 64 + int'(w[4:0]);
    if (w[11]) off = int'(w[12]) * 16384 + int'(r[13:0]);
    else       off = int'(r[14:0]);
    return AW'(bank * 32768 + off);
  endfunction

  function automatic logic [1:0] exp_mir(logic [15:0] w);
    if (w[10]) return 2'b10;
    if (w[13]) return 2'b01;
    return 2'b00;
  endfunction

  task automatic fail_line(string req, int sz, string what, longint act, longint exp);
    errors++;
    $display("FAIL %s size=%0dMiB %s actual=%0h expected=%0h", req, sz, what, act, exp);
  endtask

  task automatic do_write(logic [15:0] w, logic strobe);
    @(negedge clk);
    cpu_wr_addr = w;
    cpu_wr_en = strobe;
    @(negedge clk);
    cpu_wr_en = 1'b0;
  endtask

  // one read on all four variants, checked against last latched write
  task automatic do_read(logic [15:0] r, string req);
    @(negedge clk);
    rd_addr = r;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      logic eb = exp_bus(i + 1, last_w[i], r);
      checks++;
      if (ob[i] !== eb) fail_line(req, i + 1, "open_bus", ob[i], eb);
      if (r[15] && !eb) begin
        logic [AW-1:0] ea = exp_addr(i + 1, last_w[i], r);
        checks++;
        if (pa[i] !== ea) fail_line(req, i + 1, "prg_addr", pa[i], ea);
      end
      checks++;
      if (mm[i] !== exp_mir(last_w[i])) fail_line("R8", i + 1, "mirror", mm[i], exp_mir(last_w[i]));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    wd_fired = 1;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] lows [4] = '{5'd0, 5'd1, 5'd10, 5'd31};
    for (int i = 0; i < 4; i++) last_w[i] = 16'h8000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    do_read(16'h8000, "R9");
    do_read(16'hFFFF, "R9");
    do_read(16'h1234, "R10");

    // main sweep: R2 R3 R4 R5 R6 R7 R8 R10
    for (int sel = 0; sel < 4; sel++)
      for (int li = 0; li < 4; li++)
        for (int md = 0; md < 16; md++) begin
          logic [15:0] w = 16'h8000;
          w[9:8] = 2'(sel);
          w[4:0] = lows[li];
          w[11] = md[0];
          w[12] = md[1];
          w[10] = md[2];
          w[13] = md[3];
          w[7:5] = 3'(li);
          do_write(w, 1'b1);
          for (int k = 0; k < 4; k++) last_w[k] = w;
          do_read(16'h8000, w[11] ? "R3" : "R2");
          do_read(16'hBFFF, w[11] ? "R3" : "R2");
          do_read(16'hC5A3, sel == 0 ? "R7" : (sel == 1 ? "R4" : (sel == 2 ? "R5" : "R6")));
          do_read(16'h7FFF, "R10");
        end

    // R1: strobed write below window, then window address without strobe
    begin
      logic [15:0] w = 16'hA405;
      do_write(w, 1'b1);
      for (int k = 0; k < 4; k++) last_w[k] = w;
      do_write(16'h7B1F, 1'b1);
      do_read(16'hC001, "R1");
      do_write(16'hF91F, 1'b0);
      do_read(16'h8123, "R1");
      // R10: open-bus write then clearing write
      do_write(16'h8100, 1'b1);
      for (int k = 0; k < 4; k++) last_w[k] = 16'h8100;
      do_read(16'h9000, "R10");
      do_write(16'h8003, 1'b1);
      for (int k = 0; k < 4; k++) last_w[k] = 16'h8003;
      do_read(16'h9000, "R10");
    end

    if (!wd_fired) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule